// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

A combinational execution slice for five bit-manipulation operations on a 64-bit datapath:

- **and-not**: the inverted second operand, masked by the primary source.
- **field extract**: a bit field cut from the source. A packed control word gives its start and its length.
- **isolate lowest one**: only the lowest set bit of the source is kept.
- **smear to lowest one**: every bit up to and including the lowest set bit is set.
- **drop lowest one**: the lowest set bit is cleared.

The unit takes the opcode byte and the three-bit register sub-field of the instruction. It decodes them internally into a one-hot operation select. A width bit picks 32-bit or 64-bit operation.

Each operation has its own flag rules for zero, sign, carry and overflow. The carry flag is the most varied. For isolate it means the source was nonzero. For smear and drop it means the source was zero. For and-not and extract it is cleared. A surrounding pipeline places the unit in an execute stage, feeds it register or memory operands, and writes back the result and flags. Fetch, prefix handling, register access and memory operands are outside the unit.

Top module: `bmu_bitops_unit`

## Requirements
- R1: The operation is chosen as follows:
  - opcode 8'hF2 selects and-not;
  - opcode 8'hF7 selects field extract;
  - opcode 8'hF3 with sub-field 1 selects drop, with 2 selects smear, and with 3 selects isolate.
  
  Every other opcode or sub-field combination drives the result and all four flags to 0.
- R2: And-not returns `~src_aux & src_rm`. Zero and sign come from the result. Carry and overflow are 0.
- R3: Field extract takes its start from `src_aux[7:0]` and its length from `src_aux[15:8]`. The result is the source shifted right by start, keeping only the low `length` bits. Zero comes from the result. Carry and sign are 0.
- R4: For field extract, a start at or beyond the operand width gives 0. A length at or beyond the operand width keeps every remaining shifted bit.
- R5: Isolate returns `(-src) & src`. Zero and sign come from the result. Carry is 1 exactly when the source is nonzero.
- R6: Smear returns `(src - 1) ^ src`. Carry is 1 exactly when the source is zero, sign is the result's top bit, and zero is always 0.
- R7: Drop returns `(src - 1) & src`. Carry is 1 exactly when the source is zero. Zero and sign come from the result.
- R8: With `wide_sel` = 0, the upper 32 bits of both operands are ignored, the upper 32 result bits are 0, and sign is taken from bit 31. With `wide_sel` = 1, sign is taken from bit 63.
- R9: Overflow is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_byte | input | 8 | Opcode byte of the instruction |
| modrm_reg | input | 3 | Register sub-field choosing among the shared-opcode operations |
| wide_sel | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| src_rm | input | 64 | Primary source operand |
| src_aux | input | 64 | Second operand (and-not) or packed control word (extract) |
| result | output | 64 | Operation result |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The unit holds no state. A wrong internal value therefore shows at the ports in the same evaluation as the input that exposes it, and it disappears as soon as the inputs change.

A faulty decode shows as a wrong result for a legal opcode, or as a nonzero result for an illegal one. A wrong width mask shows as ones in the upper half during 32-bit work, or as a sign flag taken from the wrong bit.

Faults in the lowest-set-bit arithmetic stand out mainly at a zero source and at single-bit sources. Extract boundary faults appear only with a start or length near 32 or 64. The directed cases therefore sit on those values.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;
  localparam int OP_N = 5;
  localparam int OPI_ANDNOT  = 0;
  localparam int OPI_FIELD   = 1;
  localparam int OPI_ISOLATE = 2;
  localparam int OPI_SMEAR   = 3;
  localparam int OPI_DROP    = 4;

  localparam logic [7:0] OPC_ANDNOT = 8'hF2;
  localparam logic [7:0] OPC_FIELD  = 8'hF7;
  localparam logic [7:0] OPC_LOWBIT = 8'hF3;

  localparam logic [2:0] SUB_DROP    = 3'd1;
  localparam logic [2:0] SUB_SMEAR   = 3'd2;
  localparam logic [2:0] SUB_ISOLATE = 3'd3;

  localparam int CTL_FIELD_W = 8;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic o;
  } flags_t;
endpackage

// File: rtl/bmu_op_decode.sv
`timescale 1ns/1ps
module bmu_op_decode
  import bmu_pkg::*;
(
  input  logic [7:0]      opcode_byte,
  input  logic [2:0]      modrm_reg,
  output logic [OP_N-1:0] op_sel
);
  always_comb begin
    op_sel = '0;
    unique case (opcode_byte)
      OPC_ANDNOT: op_sel[OPI_ANDNOT] = 1'b1;
      OPC_FIELD:  op_sel[OPI_FIELD]  = 1'b1;
      OPC_LOWBIT: begin
        op_sel[OPI_DROP]    = (modrm_reg == SUB_DROP);
        op_sel[OPI_SMEAR]   = (modrm_reg == SUB_SMEAR);
        op_sel[OPI_ISOLATE] = (modrm_reg == SUB_ISOLATE);
      end
      default: op_sel = '0;
    endcase
  end

  always_comb begin
    AST_DECODE_ONEHOT: assert ($onehot0(op_sel)) else $error("decode not one-hot"); // R1
  end
endmodule

// File: rtl/bmu_field_extract.sv
`timescale 1ns/1ps
module bmu_field_extract
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]      src,
  input  logic [CTL_FIELD_W-1:0] start,
  input  logic [CTL_FIELD_W-1:0] len,
  input  logic [8:0]             act_w,
  output logic [DATA_W-1:0]      field
);
  localparam logic [DATA_W-1:0] ONE_V = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] fn_field(
    input logic [DATA_W-1:0]      s,
    input logic [CTL_FIELD_W-1:0] st,
    input logic [CTL_FIELD_W-1:0] ln,
    input logic [8:0]             w
  );
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep;
    shifted = ({1'b0, st} >= w) ? '0 : (s >> st);
    keep    = ({1'b0, ln} >= w) ? '1 : ((ONE_V << ln) - ONE_V);
    return shifted & keep;
  endfunction

  assign field = fn_field(src, start, len, act_w);

  always_comb begin
    AST_FIELD_START_RANGE: assert (!({1'b0, start} >= act_w) || field == '0)
      else $error("start beyond width gave nonzero"); // R4
  end
endmodule

// File: rtl/bmu_lowbit.sv
`timescale 1ns/1ps
module bmu_lowbit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] wmask,
  output logic [DATA_W-1:0] isolate_v,
  output logic [DATA_W-1:0] smear_v,
  output logic [DATA_W-1:0] drop_v,
  output logic              src_nz
);
  localparam logic [DATA_W-1:0] ONE_V = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] fn_isolate(input logic [DATA_W-1:0] s);
    return (~s + ONE_V) & s;
  endfunction

  function automatic logic [DATA_W-1:0] fn_smear(input logic [DATA_W-1:0] s);
    return (s - ONE_V) ^ s;
  endfunction

  function automatic logic [DATA_W-1:0] fn_drop(input logic [DATA_W-1:0] s);
    return (s - ONE_V) & s;
  endfunction

  assign isolate_v = fn_isolate(src) & wmask;
  assign smear_v   = fn_smear(src) & wmask;
  assign drop_v    = fn_drop(src) & wmask;
  assign src_nz    = |src;

  always_comb begin
    AST_ISOLATE_SINGLE: assert ($onehot0(isolate_v)) else $error("isolate kept several bits"); // R5
    AST_DROP_ONE_LESS: assert (!src_nz || ($countones(drop_v) + 1 == $countones(src)))
      else $error("drop did not clear exactly one bit"); // R7
  end
endmodule

// File: rtl/bmu_bitops_unit.sv
`timescale 1ns/1ps
module bmu_bitops_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [7:0]        opcode_byte,
  input  logic [2:0]        modrm_reg,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] src_rm,
  input  logic [DATA_W-1:0] src_aux,
  output logic [DATA_W-1:0] result,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_carry,
  output logic              flag_ovf
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [8:0]        WIDE_W9     = 9'(DATA_W);
  localparam logic [8:0]        HALF_W9     = 9'(HALF_W);

  logic [OP_N-1:0]   op_sel;
  logic [DATA_W-1:0] wmask;
  logic [8:0]        act_w;
  logic [DATA_W-1:0] rm_n;
  logic [DATA_W-1:0] aux_n;
  logic [DATA_W-1:0] field_v;
  logic [DATA_W-1:0] isolate_v;
  logic [DATA_W-1:0] smear_v;
  logic [DATA_W-1:0] drop_v;
  logic              src_nz;
  logic              top_bit;
  flags_t            fl;

  assign wmask = wide_sel ? '1 : NARROW_MASK;
  assign act_w = wide_sel ? WIDE_W9 : HALF_W9;
  assign rm_n  = src_rm & wmask;
  assign aux_n = src_aux & wmask;

  bmu_op_decode u_decode (
    .opcode_byte (opcode_byte),
    .modrm_reg   (modrm_reg),
    .op_sel      (op_sel)
  );

  bmu_field_extract #(.DATA_W(DATA_W)) u_field (
    .src   (rm_n),
    .start (aux_n[CTL_FIELD_W-1:0]),
    .len   (aux_n[2*CTL_FIELD_W-1:CTL_FIELD_W]),
    .act_w (act_w),
    .field (field_v)
  );

  bmu_lowbit #(.DATA_W(DATA_W)) u_lowbit (
    .src       (rm_n),
    .wmask     (wmask),
    .isolate_v (isolate_v),
    .smear_v   (smear_v),
    .drop_v    (drop_v),
    .src_nz    (src_nz)
  );

  always_comb begin
    result = '0;
    if (op_sel[OPI_ANDNOT])  result = ~aux_n & rm_n;
    if (op_sel[OPI_FIELD])   result = field_v;
    if (op_sel[OPI_ISOLATE]) result = isolate_v;
    if (op_sel[OPI_SMEAR])   result = smear_v;
    if (op_sel[OPI_DROP])    result = drop_v;
  end

  assign top_bit = wide_sel ? result[DATA_W-1] : result[HALF_W-1];

  always_comb begin
    fl = '0;
    if (op_sel[OPI_ANDNOT]) begin
      fl.z = (result == '0);
      fl.s = top_bit;
    end
    if (op_sel[OPI_FIELD]) begin
      fl.z = (result == '0);
    end
    if (op_sel[OPI_ISOLATE]) begin
      fl.z = (result == '0);
      fl.s = top_bit;
      fl.c = src_nz;
    end
    if (op_sel[OPI_SMEAR]) begin
      fl.s = top_bit;
      fl.c = !src_nz;
    end
    if (op_sel[OPI_DROP]) begin
      fl.z = (result == '0);
      fl.s = top_bit;
      fl.c = !src_nz;
    end
  end

  assign flag_zero  = fl.z;
  assign flag_sign  = fl.s;
  assign flag_carry = fl.c;
  assign flag_ovf   = fl.o;

  always_comb begin
    AST_IDLE_QUIET: assert (op_sel != '0 || (result == '0 && !flag_zero && !flag_sign && !flag_carry))
      else $error("unselected op drove outputs"); // R1
    AST_FIELD_FLAGS: assert (!op_sel[OPI_FIELD] || (!flag_sign && !flag_carry))
      else $error("extract flags"); // R3
    AST_ISOLATE_CARRY: assert (!op_sel[OPI_ISOLATE] || (flag_carry == (result != '0)))
      else $error("isolate carry"); // R5
    AST_SMEAR_NONZERO: assert (!op_sel[OPI_SMEAR] || (result != '0 && !flag_zero))
      else $error("smear gave zero"); // R6
    AST_NARROW_UPPER: assert (wide_sel || result[DATA_W-1:HALF_W] == '0)
      else $error("upper half not zero"); // R8
    AST_NO_OVERFLOW: assert (!flag_ovf) else $error("overflow set"); // R9
  end
endmodule

// File: tb/test_bmu_bitops_unit.sv
`timescale 1ns/1ps
module test_bmu_bitops_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opcode_byte = 8'h00;
  logic [2:0]  modrm_reg = 3'd0;
  logic        wide_sel = 1'b1;
  logic [63:0] src_rm = '0;
  logic [63:0] src_aux = '0;
  logic [63:0] result;
  logic        flag_zero, flag_sign, flag_carry, flag_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bmu_bitops_unit i_bmu_bitops_unit (
    .opcode_byte (opcode_byte),
    .modrm_reg   (modrm_reg),
    .wide_sel    (wide_sel),
    .src_rm      (src_rm),
    .src_aux     (src_aux),
    .result      (result),
    .flag_zero   (flag_zero),
    .flag_sign   (flag_sign),
    .flag_carry  (flag_carry),
    .flag_ovf    (flag_ovf)
  );

  // Reference packing: {ovf, carry, sign, zero, result[63:0]}
  function automatic logic [67:0] ref_calc(input logic [7:0] opc, input logic [2:0] rf,
                                           input logic [63:0] a, input logic [63:0] b,
                                           input bit wide);
    int w;
    logic [63:0] x, y, r;
    logic z, s, c;
    int lo;
    int st, ln;
    w = wide ? 64 : 32;
    x = '0; y = '0; r = '0; z = 0; s = 0; c = 0; lo = -1;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin x[i] = a[i]; y[i] = b[i]; end
    end
    for (int i = 63; i >= 0; i--) if (x[i]) lo = i;
    if (opc == 8'hF2) begin
      for (int i = 0; i < w; i++) r[i] = !y[i] && x[i];
      z = (r == 0); s = r[w-1];
    end else if (opc == 8'hF7) begin
      st = int'(y[7:0]); ln = int'(y[15:8]);
      for (int i = 0; i < w; i++)
        if (i < ln && st + i < w) r[i] = x[st+i];
      z = (r == 0);
    end else if (opc == 8'hF3 && rf == 3'd3) begin
      if (lo >= 0) r[lo] = 1'b1;
      c = (lo >= 0); z = (r == 0); s = r[w-1];
    end else if (opc == 8'hF3 && rf == 3'd2) begin
      for (int i = 0; i < w; i++) r[i] = (lo < 0) || (i <= lo);
      c = (lo < 0); s = r[w-1];
    end else if (opc == 8'hF3 && rf == 3'd1) begin
      r = x;
      if (lo >= 0) r[lo] = 1'b0;
      c = (lo < 0); z = (r == 0); s = r[w-1];
    end
    return {1'b0, c, s, z, r};
  endfunction

  task automatic chk(input string req, input logic [67:0] exp);
    logic [67:0] act;
    act = {flag_ovf, flag_carry, flag_sign, flag_zero, result};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h sub=%0d wide=%0d rm=%h aux=%h actual=%h expected=%h",
               req, opcode_byte, modrm_reg, wide_sel, src_rm, src_aux, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [7:0] opc, input logic [2:0] rf,
                       input logic [63:0] a, input logic [63:0] b, input bit wide);
    @(negedge clk);
    opcode_byte = opc; modrm_reg = rf; src_rm = a; src_aux = b; wide_sel = wide;
    #1;
    chk(req, ref_calc(opc, rf, a, b, wide));
  endtask

  task automatic apply_lit(input string req, input logic [7:0] opc, input logic [2:0] rf,
                           input logic [63:0] a, input logic [63:0] b, input bit wide,
                           input logic [67:0] exp);
    @(negedge clk);
    opcode_byte = opc; modrm_reg = rf; src_rm = a; src_aux = b; wide_sel = wide;
    #1;
    chk(req, exp);
  endtask

  task automatic t_reset();
    apply_lit("R1 idle", 8'h00, 3'd0, 64'h0, 64'h0, 1'b1, 68'h0);
  endtask

  task automatic t_decode(); // R1
    apply("R1", 8'hF3, 3'd0, 64'hF0F0, 64'h1, 1'b1);
    for (int k = 4; k < 8; k++) apply("R1", 8'hF3, 3'(k), 64'hF0F0, 64'h1, 1'b1);
    apply("R1", 8'hF4, 3'd1, 64'hFFFF, 64'h0, 1'b1);
    apply("R1", 8'hF6, 3'd3, 64'h8000_0000_0000_0001, 64'h0, 1'b0);
    apply_lit("R1 ill", 8'h0F, 3'd2, 64'h1234, 64'h5678, 1'b1, 68'h0);
  endtask

  task automatic t_andnot(); // R2
    apply_lit("R2", 8'hF2, 3'd0, 64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1,
              {4'b0010, 64'hF000_F000_F000_F000});
    apply("R2", 8'hF2, 3'd5, 64'h1234, 64'hFFFF, 1'b1);
    apply("R2", 8'hF2, 3'd0, 64'hDEAD_BEEF_0000_0001, 64'h0000_0001_0000_0000, 1'b1);
  endtask

  task automatic t_field(); // R3
    apply_lit("R3", 8'hF7, 3'd0, 64'h0000_0000_00AB_CD00, 64'h0000_0000_0000_0808, 1'b1,
              {4'b0000, 64'h0000_0000_0000_00CD});
    apply("R3", 8'hF7, 3'd0, 64'hFFFF_0000_1234_5678, 64'hFFFF_0000_0000_1004, 1'b1);
    apply("R3", 8'hF7, 3'd0, 64'h0F, 64'h0404, 1'b1);
  endtask

  task automatic t_field_edges(); // R4
    apply("R4", 8'hF7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000, 1'b1);
    apply("R4", 8'hF7, 3'd0, 64'h8000_0000_0000_0000, 64'h013F, 1'b1);
    apply_lit("R4 start", 8'hF7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0840, 1'b1,
              {4'b0001, 64'h0});
    apply("R4", 8'hF7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10C8, 1'b1);
    apply_lit("R4 len", 8'hF7, 3'd0, 64'hF234_5678_9ABC_DEF0, 64'h4004, 1'b1,
              {4'b0000, 64'h0F23_4567_89AB_CDEF});
    apply("R4", 8'hF7, 3'd0, 64'hF234_5678_9ABC_DEF0, 64'hFF00, 1'b1);
    apply("R4", 8'hF7, 3'd0, 64'hFFFF_FFFF_8000_0000, 64'h201F, 1'b0);
    apply_lit("R4 narrow", 8'hF7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0820, 1'b0,
              {4'b0001, 64'h0});
  endtask

  task automatic t_isolate(); // R5
    apply_lit("R5 zero", 8'hF3, 3'd3, 64'h0, 64'h0, 1'b1, {4'b0001, 64'h0});
    apply_lit("R5 top", 8'hF3, 3'd3, 64'h8000_0000_0000_0000, 64'h0, 1'b1,
              {4'b0110, 64'h8000_0000_0000_0000});
    apply("R5", 8'hF3, 3'd3, 64'h0000_0100_0F00_0000, 64'h0, 1'b1);
  endtask

  task automatic t_smear(); // R6
    apply_lit("R6 zero", 8'hF3, 3'd2, 64'h0, 64'h0, 1'b1, {4'b0110, 64'hFFFF_FFFF_FFFF_FFFF});
    apply_lit("R6 one", 8'hF3, 3'd2, 64'h1, 64'h0, 1'b1, {4'b0000, 64'h1});
    apply("R6", 8'hF3, 3'd2, 64'h0000_0000_0000_0A00, 64'h0, 1'b1);
  endtask

  task automatic t_drop(); // R7
    apply_lit("R7 zero", 8'hF3, 3'd1, 64'h0, 64'h0, 1'b1, {4'b0101, 64'h0});
    apply_lit("R7 single", 8'hF3, 3'd1, 64'h0000_0040_0000_0000, 64'h0, 1'b1, {4'b0001, 64'h0});
    apply("R7", 8'hF3, 3'd1, 64'hC000_0000_0000_0100, 64'h0, 1'b1);
  endtask

  task automatic t_narrow(); // R8
    apply_lit("R8 smear", 8'hF3, 3'd2, 64'hFFFF_FFFF_0000_0000, 64'h0, 1'b0,
              {4'b0110, 64'h0000_0000_FFFF_FFFF});
    apply_lit("R8 andnot", 8'hF2, 3'd0, 64'hFFFF_FFFF_8000_0000, 64'h0, 1'b0,
              {4'b0010, 64'h0000_0000_8000_0000});
    apply("R8", 8'hF3, 3'd3, 64'h0000_0001_0000_0000, 64'h0, 1'b0);
    apply("R8", 8'hF3, 3'd1, 64'hABCD_0000_0000_0003, 64'h0, 1'b0);
  endtask

  task automatic t_sweep(); // R2..R9 random mix
    logic [63:0] lf;
    logic [7:0]  opcs [5];
    logic [2:0]  subs [5];
    lf = 64'h9E37_79B9_7F4A_7C15;
    opcs = '{8'hF2, 8'hF7, 8'hF3, 8'hF3, 8'hF3};
    subs = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3};
    for (int n = 0; n < 40; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      for (int k = 0; k < 5; k++) begin
        apply("R9 sweep", opcs[k], subs[k], lf & (64'hFFFF_FFFF_FFFF_FFFF >> (n % 64)),
              {lf[31:0], lf[63:48], 2'b00, lf[5:0], 1'b0, lf[12:6]}, n[0]);
      end
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_andnot();
    t_field();
    t_field_edges();
    t_isolate();
    t_smear();
    t_drop();
    t_narrow();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule